// File: doc/BRIEF.md
# AXI ID-Masked Traffic Filter

This block observes three AXI handshake streams: the read address channel, the write address channel and the read data channel. For each stream it produces a single-cycle count pulse. A pulse is raised only when the handshake completes, the handshake's ID matches a programmed ID under a programmed mask, and the stream's filter is enabled. The three pulses are meant to drive counters of a performance counter bank. Read transactions drive counter 2, write transactions drive counter 3 and read beats drive counter 4. A counter takes the pulse as its event source when software selects the reserved event code 73 for it. Any other event code leaves the matching enable bit cleared.

Software programs the block through a simple register write port. One register holds the three enable bits and the 18-bit mask. A second register holds the 18-bit ID to compare against. Every output pulse comes from a flop, so a count pulse appears exactly one clock after the handshake that caused it. The block does not check AXI protocol rules.

Top module: `axif_id_filter`

## Requirements
- R1: While reset is asserted, and directly after it, all three count outputs are 0. All enables, the mask and the match ID reset to 0.
- R2: A write to offset 0x0 loads the enable bits and the mask. Bit 31 enables the read-transaction filter, bit 30 the write-transaction filter, bit 29 the read-beat filter, and bits 17:0 hold the mask. A write to offset 0x4 loads bits 17:0 as the match ID.
- R3: An incoming ID matches when (ID AND mask) equals (match ID AND mask). A mask of all zeros matches every ID.
- R4: `cnt_rd_txn` is 1 for exactly one cycle, in the cycle after each read-address handshake (valid and ready both high) whose ID matches.
- R5: `cnt_wr_txn` is 1 for exactly one cycle, in the cycle after each write-address handshake whose ID matches.
- R6: `cnt_rd_beat` is 1 for exactly one cycle, in the cycle after each read-data handshake whose ID matches. Back-to-back beats give back-to-back pulses.
- R7: When a stream's enable bit is 0, its count output stays 0 whatever the traffic.
- R8: Valid without ready, or ready without valid, produces no pulse.
- R9: Register writes to offsets other than 0x0 and 0x4 change nothing. Without a write, the configuration holds.
- R10: A configuration write applies to handshakes in the cycles after the write. A handshake in the same cycle as the write is filtered with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register byte offset |
| cfg_wr_data | input | 32 | Register write data |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 18 | Read address ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 18 | Write address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | 18 | Read data ID |
| cnt_rd_txn | output | 1 | Filtered read-transaction pulse |
| cnt_wr_txn | output | 1 | Filtered write-transaction pulse |
| cnt_rd_beat | output | 1 | Filtered read-beat pulse |

## Verification
The assertions assume that the handshake inputs and register write inputs are synchronous to `clk` and hold known values once reset is released. They compare each pulse against the previous cycle's handshake, ID match and enable. The stimulus changes all inputs on the falling edge and holds every input at a defined level throughout. Each stimulus vector holds its traffic for a single cycle, so every pulse can be traced to one handshake.

// File: rtl/axif_pkg.sv
package axif_pkg;
  // channel index; also fixes the enable bit position (DATA_W-1-index)
  typedef enum logic [1:0] {
    CH_RD_TXN  = 2'd0,
    CH_WR_TXN  = 2'd1,
    CH_RD_BEAT = 2'd2
  } axif_ch_e;

  localparam int unsigned NUM_CH     = 3;
  localparam int unsigned OFS_CTRL   = 0;  // enables + mask
  localparam int unsigned OFS_MATCH  = 4;  // match ID
endpackage

// File: rtl/axif_cfg_regs.sv
module axif_cfg_regs #(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NCH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    en_q,
  output logic [ID_W-1:0]   mask_q,
  output logic [ID_W-1:0]   match_q
);
  import axif_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);

  logic            ctrl_we, match_we;
  logic [NCH-1:0]  en_d;
  logic [ID_W-1:0] mask_d, match_d;

  always_comb begin
    ctrl_we  = wr_en && (wr_addr == A_CTRL);
    match_we = wr_en && (wr_addr == A_MATCH);
    en_d     = en_q;
    mask_d   = mask_q;
    match_d  = match_q;
    if (ctrl_we) begin
      for (int c = 0; c < NCH; c++) en_d[c] = wr_data[DATA_W-1-c];
      mask_d = wr_data[ID_W-1:0];
    end
    if (match_we) match_d = wr_data[ID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      match_q <= '0;
    end else begin
      if (ctrl_we) begin
        en_q   <= en_d;
        mask_q <= mask_d;
      end
      if (match_we) match_q <= match_d;
    end
  end

  AST_CFG_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({en_q, mask_q, match_q})); // R9
  AST_CFG_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != A_CTRL && wr_addr != A_MATCH)
      |=> $stable({en_q, mask_q, match_q})); // R9
  AST_MATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MATCH) |=> match_q == $past(wr_data[ID_W-1:0])); // R2
endmodule

// File: rtl/axif_id_match.sv
module axif_id_match #(
  parameter int unsigned ID_W = 18
) (
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] match,
  input  logic [ID_W-1:0] mask,
  output logic            hit
);
  // bits outside the mask never disqualify
  always_comb hit = ((id ^ match) & mask) == '0;
endmodule

// File: rtl/axif_pulse_chan.sv
module axif_pulse_chan #(
  parameter int unsigned ID_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] match,
  input  logic [ID_W-1:0] mask,
  output logic            pulse_q
);
  logic hit, fire, pulse_d;

  axif_id_match #(.ID_W(ID_W)) match_i (
    .id(id), .match(match), .mask(mask), .hit(hit)
  );

  always_comb begin
    fire    = valid && ready;
    pulse_d = fire && hit && en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  AST_PULSE_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(valid && ready)); // R8
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(en)); // R7
  AST_PULSE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past((id & mask) == (match & mask))); // R3
  AST_HS_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && en && ((id & mask) == (match & mask))) |=> pulse_q); // R4
endmodule

// File: rtl/axif_id_filter.sv
module axif_id_filter #(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              cnt_rd_txn,
  output logic              cnt_wr_txn,
  output logic              cnt_rd_beat
);
  import axif_pkg::*;

  localparam int unsigned NCH = NUM_CH;

  logic [NCH-1:0]  en_q;
  logic [ID_W-1:0] mask_q, match_q;
  logic [NCH-1:0]  ch_valid, ch_ready, ch_pulse;
  logic [ID_W-1:0] ch_id [NCH];

  axif_cfg_regs #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .en_q(en_q), .mask_q(mask_q), .match_q(match_q)
  );

  always_comb begin
    ch_valid[CH_RD_TXN]  = ar_valid;
    ch_ready[CH_RD_TXN]  = ar_ready;
    ch_id[CH_RD_TXN]     = ar_id;
    ch_valid[CH_WR_TXN]  = aw_valid;
    ch_ready[CH_WR_TXN]  = aw_ready;
    ch_id[CH_WR_TXN]     = aw_id;
    ch_valid[CH_RD_BEAT] = r_valid;
    ch_ready[CH_RD_BEAT] = r_ready;
    ch_id[CH_RD_BEAT]    = r_id;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    axif_pulse_chan #(.ID_W(ID_W)) chan_i (
      .clk(clk), .rst_n(rst_n), .en(en_q[c]),
      .valid(ch_valid[c]), .ready(ch_ready[c]), .id(ch_id[c]),
      .match(match_q), .mask(mask_q), .pulse_q(ch_pulse[c])
    );
  end

  assign cnt_rd_txn  = ch_pulse[CH_RD_TXN];
  assign cnt_wr_txn  = ch_pulse[CH_WR_TXN];
  assign cnt_rd_beat = ch_pulse[CH_RD_BEAT];

  AST_WR_FROM_AW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_txn |-> $past(aw_valid && aw_ready)); // R5
  AST_BEAT_FROM_R: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_beat |-> $past(r_valid && r_ready)); // R6
endmodule

// File: tb/axif_id_filter_tb.sv
module axif_id_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 18;

  typedef struct packed {
    logic [IW-1:0] msk;
    logic [IW-1:0] mid;
    logic [2:0]    en;   // [2] rd txn, [1] wr txn, [0] rd beat
    logic          arv, arr;
    logic [IW-1:0] arid;
    logic          awv, awr;
    logic [IW-1:0] awid;
    logic          rv, rr;
    logic [IW-1:0] rid;
    logic [2:0]    exp;  // {rd_txn, wr_txn, rd_beat}
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R3 zero mask matches all
    '{msk:18'h0, mid:18'h5, en:3'b111, arv:1, arr:1, arid:18'h123, awv:1, awr:1, awid:18'h7,
      rv:1, rr:1, rid:18'h3FFFF, exp:3'b111},
    // R3 full mask exact compare
    '{msk:18'h3FFFF, mid:18'h10, en:3'b111, arv:1, arr:1, arid:18'h10, awv:1, awr:1, awid:18'h11,
      rv:1, rr:1, rid:18'h10, exp:3'b101},
    // R3 low-nibble mask
    '{msk:18'h0000F, mid:18'h5, en:3'b111, arv:1, arr:1, arid:18'h125, awv:1, awr:1, awid:18'h0F4,
      rv:1, rr:1, rid:18'h3FF05, exp:3'b101},
    // R7 all disabled
    '{msk:18'h0, mid:18'h0, en:3'b000, arv:1, arr:1, arid:18'h1, awv:1, awr:1, awid:18'h2,
      rv:1, rr:1, rid:18'h3, exp:3'b000},
    // R5 only write enabled
    '{msk:18'h0, mid:18'h0, en:3'b010, arv:1, arr:1, arid:18'h1, awv:1, awr:1, awid:18'h2,
      rv:1, rr:1, rid:18'h3, exp:3'b010},
    // R8 incomplete handshakes
    '{msk:18'h0, mid:18'h0, en:3'b111, arv:1, arr:0, arid:18'h1, awv:0, awr:1, awid:18'h2,
      rv:1, rr:1, rid:18'h3, exp:3'b001},
    // R3 high-bit mask
    '{msk:18'h30000, mid:18'h20000, en:3'b111, arv:1, arr:1, arid:18'h2FFFF, awv:1, awr:1,
      awid:18'h10000, rv:1, rr:1, rid:18'h20000, exp:3'b101},
    // R4 read txn only
    '{msk:18'h0, mid:18'h0, en:3'b101, arv:1, arr:1, arid:18'h9, awv:1, awr:1, awid:18'h9,
      rv:0, rr:1, rid:18'h9, exp:3'b100}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en;
  logic [3:0] cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic ar_valid, ar_ready, aw_valid, aw_ready, r_valid, r_ready;
  logic [IW-1:0] ar_id, aw_id, r_id;
  logic cnt_rd_txn, cnt_wr_txn, cnt_rd_beat;

  int n_checks = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axif_id_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .cnt_rd_txn(cnt_rd_txn), .cnt_wr_txn(cnt_wr_txn), .cnt_rd_beat(cnt_rd_beat)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%b expected=%b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {cnt_rd_txn, cnt_wr_txn, cnt_rd_beat};
  endfunction

  task automatic traffic(input logic arv, arr, input logic [IW-1:0] arid,
                         input logic awv, awr, input logic [IW-1:0] awid,
                         input logic rv, rr, input logic [IW-1:0] rid);
    ar_valid = arv; ar_ready = arr; ar_id = arid;
    aw_valid = awv; aw_ready = awr; aw_id = awid;
    r_valid = rv; r_ready = rr; r_id = rid;
  endtask

  task automatic idle();
    traffic(0, 0, '0, 0, 0, '0, 0, 0, '0);
  endtask

  // write at the next edge; returns on the negedge after it
  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [2:0] en, input logic [IW-1:0] m);
    return {en, 11'b0, m};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    traffic(1, 1, '0, 1, 1, '0, 1, 1, '0);
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset, config zero", outs(), 3'b000);
    idle();
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      reg_wr(4'h0, ctrl_word(VEC[i].en, VEC[i].msk));
      reg_wr(4'h4, {14'b0, VEC[i].mid});
      traffic(VEC[i].arv, VEC[i].arr, VEC[i].arid, VEC[i].awv, VEC[i].awr, VEC[i].awid,
              VEC[i].rv, VEC[i].rr, VEC[i].rid);
      @(negedge clk);
      idle();
      check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), outs(), VEC[i].exp);
      @(negedge clk);
      check("R4 pulse lasts one cycle", outs(), 3'b000);
    end

    // R10: enable written in same cycle as handshake -> old (disabled) config
    reg_wr(4'h0, ctrl_word(3'b000, '0));
    traffic(1, 1, 18'h1, 1, 1, 18'h1, 1, 1, 18'h1);
    cfg_wr_en = 1'b1; cfg_wr_addr = 4'h0; cfg_wr_data = ctrl_word(3'b111, '0);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R10 same-cycle write uses old config", outs(), 3'b000);
    @(negedge clk);
    check("R10 next handshake uses new config", outs(), 3'b111);

    // R6: back-to-back beats
    traffic(0, 0, '0, 0, 0, '0, 1, 1, 18'h2);
    @(negedge clk);
    check("R6 beat 1", outs(), 3'b001);
    @(negedge clk);
    check("R6 beat 2", outs(), 3'b001);
    idle();
    @(negedge clk);
    check("R6 beats end", outs(), 3'b000);

    // R9: unmapped offset write ignored (would otherwise disable or remask)
    reg_wr(4'h4, 32'h0000_0055);
    reg_wr(4'h0, ctrl_word(3'b111, 18'h3FFFF));
    reg_wr(4'h8, 32'h0000_0000);
    reg_wr(4'hC, 32'h0000_0000);
    traffic(1, 1, 18'h55, 1, 1, 18'h55, 1, 1, 18'h54);
    @(negedge clk);
    idle();
    check("R9 unmapped writes ignored", outs(), 3'b110);

    // R2: match ID write leaves enables and mask intact
    reg_wr(4'h4, 32'hFFFC_0054);
    traffic(1, 1, 18'h55, 1, 1, 18'h54, 1, 1, 18'h54);
    @(negedge clk);
    idle();
    check("R2 match write only changes ID", outs(), 3'b011);

    // R1: reset mid-run clears config
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    traffic(1, 1, 18'h54, 1, 1, 18'h54, 1, 1, 18'h54);
    @(negedge clk);
    idle();
    check("R1 reset clears enables", outs(), 3'b000);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule